// File: doc/BRIEF.md
# Far Indirect Jump Sequencer

This block steers the program counter of a small processor core when it meets a far indirect jump. The jump target is a 22-bit word address: its upper six bits come from a separate extension register and its lower sixteen bits come from a 16-bit pointer register. Joining the two lets a single one-word instruction reach any of the 4M words of program space. The block also handles ordinary sequential fetch. Any other valid instruction word moves the counter forward by one word.

The instruction is recognised only from one exact 16-bit code. A recognised jump takes two clock cycles, and `busy` is high in both. In the first cycle the fetch address holds its value, and the word already in the fetch path is thrown away. In the second cycle the joined target appears on the fetch address and `flush` tells the pipeline to discard stale work. Instruction words that arrive while `busy` is high are ignored. The block does not touch stack or status state.

Top module: `far_jump_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `fetch_addr` to 0 and clears `busy` and `flush`.
- R2: The jump is decoded only when `instr_valid` is high, the unit is idle, and `instr_word` is exactly 0x9419. After that edge `busy` is 1, `flush` is 0 and `fetch_addr` is unchanged.
- R3: After the second edge of a jump, `fetch_addr` equals {`ext_val[5:0]`, `ptr_val[15:0]`}, taken from the values present at the decode edge. With ext 0x05 and pointer 0x1000 this gives 0x051000.
- R4: `busy` stays high for exactly two cycles per jump. `flush` is high only in the second of them, and both are low after the third edge.
- R5: While `busy` is high, valid instruction words have no effect. They neither advance `fetch_addr` nor start another jump.
- R6: When the unit is idle, a valid word other than 0x9419 advances `fetch_addr` by 1 at the next edge and leaves `busy` low.
- R7: When the unit is idle and `instr_valid` is low, `fetch_addr` holds its value.
- R8: The one-word advance wraps modulo 2^22, so 0x3FFFFF is followed by 0x000000.
- R9: A word that differs from 0x9419 in any bit, such as 0x9418, 0x9409 or 0x1419, is treated as an ordinary instruction and advances by 1.
- R10: Changes to `ptr_val` or `ext_val` after the decode edge do not alter the jump target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Qualifies `instr_word` |
| instr_word | input | 16 | Fetched instruction word |
| ptr_val | input | 16 | Pointer register value (target bits 15:0) |
| ext_val | input | 6 | Extension register value (target bits 21:16) |
| fetch_addr | output | 22 | Current program counter / fetch word address |
| busy | output | 1 | High during both cycles of a jump |
| flush | output | 1 | High in the second jump cycle; discard fetched work |

## Verification
The decoder is driven with the exact jump code and with near-miss words, each differing from it in a single bit or a single nibble. This shows that the match is exact and not a partial-field decode. Jumps are issued with different extension and pointer pairs: the worked 0x05/0x1000 case, an all-ones target, and a target with the two halves distinct. This exposes swapped or truncated fields. During each jump the bench changes the register inputs and feeds both valid ordinary words and a second jump code. This separates a unit that latches its target at decode from one that samples it late, and a unit that ignores busy-time words from one that acts on them. A non-matching word sent at 0x3FFFFF shows whether the advance wraps.

// File: rtl/far_jump_pkg.sv
package far_jump_pkg;

    // Sequencer states; a jump walks HOLD then LOAD before returning to IDLE
    typedef enum logic [1:0] {
        FJ_IDLE = 2'd0,
        FJ_HOLD = 2'd1,
        FJ_LOAD = 2'd2
    } fj_state_e;

    // Exact encoding of the far indirect jump
    localparam logic [15:0] FJ_OPCODE = 16'h9419;

endpackage

// File: rtl/fj_opcode_match.sv
module fj_opcode_match #(
    parameter int              WORD_W  = 16,
    parameter logic [WORD_W-1:0] PATTERN = '0
) (
    input  logic              valid_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              hit_o
);

    logic [WORD_W-1:0] bit_eq;

    // per-bit equality against the fixed pattern
    for (genvar gi = 0; gi < WORD_W; gi++) begin : g_bit
        assign bit_eq[gi] = ~(word_i[gi] ^ PATTERN[gi]);
    end

    assign hit_o = valid_i & (&bit_eq);

endmodule

// File: rtl/fj_target_join.sv
module fj_target_join #(
    parameter int PTR_W = 16,
    parameter int EXT_W = 6,
    localparam int TGT_W = PTR_W + EXT_W
) (
    input  logic [PTR_W-1:0] ptr_i,
    input  logic [EXT_W-1:0] ext_i,
    output logic [TGT_W-1:0] target_o
);

    // low field from the pointer, high field from the extension register
    for (genvar gi = 0; gi < TGT_W; gi++) begin : g_bit
        if (gi < PTR_W) begin : g_lo
            assign target_o[gi] = ptr_i[gi];
        end else begin : g_hi
            assign target_o[gi] = ext_i[gi - PTR_W];
        end
    end

endmodule

// File: rtl/fj_pc_step.sv
module fj_pc_step #(
    parameter int PC_W = 22
) (
    input  logic [PC_W-1:0] pc_i,
    output logic [PC_W-1:0] pc_next_o
);

    localparam logic [PC_W-1:0] ONE = PC_W'(1);

    // modulo 2^PC_W advance by one word
    assign pc_next_o = pc_i + ONE;

endmodule

// File: rtl/far_jump_unit.sv
module far_jump_unit
    import far_jump_pkg::*;
#(
    parameter int INSTR_W = 16,
    parameter int PTR_W   = 16,
    parameter int EXT_W   = 6,
    localparam int PC_W   = PTR_W + EXT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr_word,
    input  logic [PTR_W-1:0]   ptr_val,
    input  logic [EXT_W-1:0]   ext_val,
    output logic [PC_W-1:0]    fetch_addr,
    output logic               busy,
    output logic               flush
);

    typedef struct packed {
        fj_state_e       state;
        logic [PC_W-1:0] pc;
        logic [PC_W-1:0] tgt;
    } seq_t;

    seq_t seq_d, seq_q;

    logic            jump_hit;
    logic [PC_W-1:0] joined_tgt;
    logic [PC_W-1:0] pc_inc;

    fj_opcode_match #(
        .WORD_W  (INSTR_W),
        .PATTERN (INSTR_W'(FJ_OPCODE))
    ) u_match (
        .valid_i (instr_valid),
        .word_i  (instr_word),
        .hit_o   (jump_hit)
    );

    fj_target_join #(
        .PTR_W (PTR_W),
        .EXT_W (EXT_W)
    ) u_join (
        .ptr_i    (ptr_val),
        .ext_i    (ext_val),
        .target_o (joined_tgt)
    );

    fj_pc_step #(
        .PC_W (PC_W)
    ) u_step (
        .pc_i      (seq_q.pc),
        .pc_next_o (pc_inc)
    );

    // next-state computation
    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            FJ_IDLE: begin
                if (jump_hit) begin
                    seq_d.state = FJ_HOLD;
                    seq_d.tgt   = joined_tgt;
                end else if (instr_valid) begin
                    seq_d.pc = pc_inc;
                end
            end
            FJ_HOLD: begin
                seq_d.state = FJ_LOAD;
                seq_d.pc    = seq_q.tgt;
            end
            FJ_LOAD: begin
                seq_d.state = FJ_IDLE;
            end
            default: begin
                seq_d.state = FJ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.state <= FJ_IDLE;
            seq_q.pc    <= '0;
            seq_q.tgt   <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign fetch_addr = seq_q.pc;
    assign busy       = (seq_q.state != FJ_IDLE);
    assign flush      = (seq_q.state == FJ_LOAD);

    logic idle_now;
    assign idle_now = (seq_q.state == FJ_IDLE);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (fetch_addr == '0 && !busy && !flush)); // R1

    AST_JUMP_HOLDS_PC: assert property (@(posedge clk) disable iff (rst)
        (idle_now && instr_valid && instr_word == INSTR_W'(FJ_OPCODE))
        |=> (busy && !flush && $stable(fetch_addr))); // R2

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (idle_now && jump_hit) |=> ##1 (fetch_addr == $past(joined_tgt, 2))); // R3

    AST_BUSY_FIRST_TO_SECOND: assert property (@(posedge clk) disable iff (rst)
        (busy && !flush) |=> (busy && flush)); // R4

    AST_FLUSH_ENDS: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!busy && !flush)); // R4

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (idle_now && instr_valid && instr_word != INSTR_W'(FJ_OPCODE))
        |=> (!busy && fetch_addr == PC_W'($past(fetch_addr) + 1'b1))); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (idle_now && !instr_valid) |=> $stable(fetch_addr)); // R7

endmodule

// File: tb/far_jump_unit_bench.sv
`timescale 1ns/1ps
module far_jump_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid;
    logic [15:0] instr_word;
    logic [15:0] ptr_val;
    logic [5:0]  ext_val;
    logic [21:0] fetch_addr;
    logic        busy;
    logic        flush;

    int n_chk  = 0;
    int n_fail = 0;
    logic [21:0] exp_pc;

    always #2 clk = ~clk;

    far_jump_unit u_far_jump_unit (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .ptr_val     (ptr_val),
        .ext_val     (ext_val),
        .fetch_addr  (fetch_addr),
        .busy        (busy),
        .flush       (flush)
    );

    task automatic chk(input string req, input logic [21:0] pc_e,
                       input logic busy_e, input logic flush_e);
        n_chk++;
        if (fetch_addr !== pc_e || busy !== busy_e || flush !== flush_e) begin
            n_fail++;
            $display("FAIL %s: addr=%h busy=%b flush=%b expected addr=%h busy=%b flush=%b",
                     req, fetch_addr, busy, flush, pc_e, busy_e, flush_e);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        rst = 1'b1; instr_valid = 1'b0; instr_word = '0; ptr_val = '0; ext_val = '0;
        tick(); tick();
        rst = 1'b0;
        exp_pc = '0;
        chk("R1 reset", exp_pc, 1'b0, 1'b0);
    endtask

    task automatic t_sequential;
        for (int i = 0; i < 3; i++) begin
            instr_valid = 1'b1; instr_word = 16'h2C01 + 16'(i);
            tick();
            exp_pc = exp_pc + 22'd1;
            chk("R6 step", exp_pc, 1'b0, 1'b0);
        end
        instr_valid = 1'b0;
    endtask

    task automatic t_idle;
        instr_valid = 1'b0; instr_word = 16'h9419;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R7 idle hold", exp_pc, 1'b0, 1'b0);
        end
    endtask

    task automatic t_near;
        logic [15:0] words [3];
        words[0] = 16'h9418; words[1] = 16'h9409; words[2] = 16'h1419;
        for (int i = 0; i < 3; i++) begin
            instr_valid = 1'b1; instr_word = words[i];
            tick();
            exp_pc = exp_pc + 22'd1;
            chk("R9 near miss", exp_pc, 1'b0, 1'b0);
        end
        instr_valid = 1'b0;
    endtask

    task automatic t_jump(input logic [5:0] e, input logic [15:0] p);
        logic [21:0] tgt;
        tgt = {e, p};
        instr_valid = 1'b1; instr_word = 16'h9419; ptr_val = p; ext_val = e;
        tick();
        chk("R2 first cycle", exp_pc, 1'b1, 1'b0);
        // disturb registers and feed an ordinary word while busy
        ptr_val = ~p; ext_val = ~e; instr_word = 16'h0001;
        tick();
        exp_pc = tgt;
        chk("R3 R10 target", exp_pc, 1'b1, 1'b1);
        // a second jump code during the flush cycle must be ignored
        instr_word = 16'h9419;
        tick();
        chk("R4 R5 end of jump", exp_pc, 1'b0, 1'b0);
        instr_valid = 1'b0;
        tick();
        chk("R5 no extra jump", exp_pc, 1'b0, 1'b0);
    endtask

    task automatic t_wrap;
        t_jump(6'h3F, 16'hFFFF);
        instr_valid = 1'b1; instr_word = 16'h0000;
        tick();
        exp_pc = 22'h000000;
        chk("R8 wrap", exp_pc, 1'b0, 1'b0);
        instr_valid = 1'b0;
    endtask

    logic done = 1'b0;

    initial begin
        t_reset();
        t_sequential();
        t_idle();
        t_near();
        t_jump(6'h05, 16'h1000);
        if (fetch_addr !== 22'h051000) begin
            n_fail++;
            $display("FAIL R3 worked case: addr=%h expected addr=051000", fetch_addr);
        end
        n_chk++;
        t_sequential();
        t_jump(6'h2A, 16'h5C3E);
        t_wrap();
        t_idle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule